// File: doc/BRIEF.md
# LIN Response Receiver with Checksum Verification

This block receives the response part of a LIN frame: a programmed number of data bytes (one to eight) followed by one checksum byte. Each byte is framed like an asynchronous serial character (low start bit, eight data bits least significant bit first, high stop bit). The line is oversampled at a fixed number of clock cycles per bit, and each bit is sampled near its centre. Reception is armed by a start command, which also latches the data length, the protected identifier, the checksum mode and a flag telling whether the response directly follows a header.

While bytes arrive, the block keeps a running one's-complement style sum with end-around carry. When the checksum byte has been received, the inverted sum is compared with it. Exactly one status pulse ends every armed reception: done, checksum error, frame error, or a distinct status for a zero first byte with a bad stop bit. A bad start or stop bit aborts reception at once, and the rest of the response is ignored until the next start command.

Top module: `lin_rsp_rx`

## Requirements
- R1: After reset the block is idle (`busy` low), `dataOut` is zero and no status pulse is active.
- R2: A `start` pulse while idle arms reception and latches `dataLen` (code n means n+1 data bytes), `pid`, `enhanced` and `afterHdr`; a `start` pulse while `busy` is high has no effect.
- R3: Each byte is a low start bit, eight data bits sent least significant bit first and a high stop bit, sampled OVS/2 cycles after the start edge and then every OVS cycles; data byte k lands in `dataOut[8k+7:8k]`, and `dataOut` is cleared by an accepted `start`.
- R4: In classic mode (`enhanced` = 0) the expected checksum is the bitwise inverse of the 8-bit sum of the data bytes, where every carry out of bit 7 is added back into the low byte.
- R5: In enhanced mode (`enhanced` = 1) the protected identifier is included in the same sum as the data bytes.
- R6: When the received checksum byte equals the expected checksum, `doneP` pulses for one cycle; otherwise `csumErrP` pulses for one cycle and `doneP` stays low.
- R7: A start bit read high at its centre, or a stop bit read low, raises a one-cycle `frameErrP`, ends reception without `doneP`, and bytes that follow are ignored.
- R8: When `afterHdr` was set, the first data byte is 0x00 and its stop bit is low, `zeroStopP` pulses instead of `frameErrP` and reception ends without `doneP`.
- R9: At most one of the four status pulses is high in any cycle, each one leaves the block idle, and `doneP` only follows a cycle in which the block was busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idle high |
| start | input | 1 | Arms reception of one response |
| dataLen | input | 3 | Number of data bytes minus one |
| pid | input | 8 | Protected identifier of the frame |
| enhanced | input | 1 | 1 includes the identifier in the checksum |
| afterHdr | input | 1 | 1 when this response directly follows a header |
| dataOut | output | 64 | Received data bytes, byte k at bits 8k+7..8k |
| busy | output | 1 | Reception armed or in progress |
| doneP | output | 1 | Response received with valid framing and checksum |
| frameErrP | output | 1 | Bad start or stop bit, reception aborted |
| csumErrP | output | 1 | Checksum mismatch |
| zeroStopP | output | 1 | Zero first byte with bad stop bit after a header |

## Verification
On every cycle the assertions check that the status pulses never overlap, that each pulse leaves the block idle, that a start command while idle always arms it, that done comes only out of a busy state, and that no data byte is written beyond the eighth slot. Whether the checksum arithmetic with end-around carry is right, whether the identifier enters the sum only in enhanced mode, whether bits are assembled least significant first, and which of frame error or zero-byte status a bad stop bit produces can only be shown by the bench's scenarios, which compare the pulses and the captured bytes against a behavioural model of each frame.

// File: rtl/lin_rsp_pkg.sv
package lin_rsp_pkg;
  localparam int MAX_BYTES = 8;
  localparam int LEN_W = $clog2(MAX_BYTES);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic             clr;     // new reception armed
    logic             shift;   // sample one data bit
    logic             commit;  // store finished data byte and add it to the sum
    logic             bitVal;  // synchronized line value
    logic [IDX_W-1:0] idx;     // index of the byte in flight
  } rspStrb_t;

  function automatic logic [7:0] addCarry(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_rsp_dp.sv
module lin_rsp_dp
  import lin_rsp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  rspStrb_t               strb,
  input  logic [7:0]             pid,
  input  logic                   enhanced,
  output logic [8*MAX_BYTES-1:0] dataOut,
  output logic [7:0]             shByte,
  output logic                   csumMatch
);
  logic [7:0] sumQ;
  logic [7:0] shQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= 8'd0;
      shQ  <= 8'd0;
    end else begin
      if (strb.clr) sumQ <= enhanced ? pid : 8'd0;
      else if (strb.commit) sumQ <= addCarry(sumQ, shQ);
      if (strb.shift) shQ <= {strb.bitVal, shQ[7:1]};
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] byteQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) byteQ <= 8'd0;
      else if (strb.clr) byteQ <= 8'd0;
      else if (strb.commit && (strb.idx == IDX_W'(g))) byteQ <= shQ;
    end
    assign dataOut[8*g +: 8] = byteQ;
  end

  assign shByte    = shQ;
  assign csumMatch = (shQ == ~sumQ);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.idx < IDX_W'(MAX_BYTES)));
endmodule

// File: rtl/lin_rsp_ctrl.sv
module lin_rsp_ctrl
  import lin_rsp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             start,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             afterHdr,
  input  logic [7:0]       shByte,
  input  logic             csumMatch,
  output rspStrb_t         strb,
  output logic             busy,
  output logic             doneP,
  output logic             frameErrP,
  output logic             csumErrP,
  output logic             zeroStopP
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_START, S_BITS, S_STOP} state_t;
  state_t           state;
  logic             rxMeta, rxS;
  logic [CW-1:0]    cnt;
  logic [2:0]       bitIdx;
  logic [IDX_W-1:0] byteIdx, lastIdx;
  logic             hdrQ;
  logic             bitTick, midStart;

  assign bitTick  = (cnt == CW'(OVS - 1));
  assign midStart = (cnt == CW'(HALF - 1));
  assign busy     = (state != S_IDLE);

  always_comb begin
    strb.clr    = (state == S_IDLE) && start;
    strb.shift  = (state == S_BITS) && bitTick;
    strb.commit = (state == S_STOP) && bitTick && rxS && (byteIdx != lastIdx);
    strb.bitVal = rxS;
    strb.idx    = byteIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta    <= 1'b1;
      rxS       <= 1'b1;
      state     <= S_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      byteIdx   <= '0;
      lastIdx   <= '0;
      hdrQ      <= 1'b0;
      doneP     <= 1'b0;
      frameErrP <= 1'b0;
      csumErrP  <= 1'b0;
      zeroStopP <= 1'b0;
    end else begin
      rxMeta    <= rxIn;
      rxS       <= rxMeta;
      doneP     <= 1'b0;
      frameErrP <= 1'b0;
      csumErrP  <= 1'b0;
      zeroStopP <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          lastIdx <= IDX_W'(dataLen) + IDX_W'(1);
          byteIdx <= '0;
          hdrQ    <= afterHdr;
          state   <= S_HUNT;
        end
        S_HUNT: if (!rxS) begin
          cnt   <= '0;
          state <= S_START;
        end
        S_START: begin
          if (midStart) begin
            cnt <= '0;
            if (rxS) begin
              frameErrP <= 1'b1;
              state     <= S_IDLE;
            end else begin
              bitIdx <= '0;
              state  <= S_BITS;
            end
          end else cnt <= cnt + CW'(1);
        end
        S_BITS: begin
          if (bitTick) begin
            cnt    <= '0;
            bitIdx <= bitIdx + 3'd1;
            if (bitIdx == 3'd7) state <= S_STOP;
          end else cnt <= cnt + CW'(1);
        end
        S_STOP: begin
          if (bitTick) begin
            cnt <= '0;
            if (!rxS) begin
              if (byteIdx == '0 && hdrQ && shByte == 8'h00) zeroStopP <= 1'b1;
              else frameErrP <= 1'b1;
              state <= S_IDLE;
            end else if (byteIdx == lastIdx) begin
              if (csumMatch) doneP <= 1'b1;
              else csumErrP <= 1'b1;
              state <= S_IDLE;
            end else begin
              byteIdx <= byteIdx + IDX_W'(1);
              state   <= S_HUNT;
            end
          end else cnt <= cnt + CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneP, frameErrP, csumErrP, zeroStopP}));
  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneP || frameErrP || csumErrP || zeroStopP) |-> !busy);
  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneP) |-> $past(busy));
  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

// File: rtl/lin_rsp_rx.sv
module lin_rsp_rx
  import lin_rsp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxIn,
  input  logic                   start,
  input  logic [LEN_W-1:0]       dataLen,
  input  logic [7:0]             pid,
  input  logic                   enhanced,
  input  logic                   afterHdr,
  output logic [8*MAX_BYTES-1:0] dataOut,
  output logic                   busy,
  output logic                   doneP,
  output logic                   frameErrP,
  output logic                   csumErrP,
  output logic                   zeroStopP
);
  rspStrb_t   strb;
  logic [7:0] shByte;
  logic       csumMatch;

  lin_rsp_ctrl #(.OVS(OVS)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .start(start), .dataLen(dataLen),
    .afterHdr(afterHdr), .shByte(shByte), .csumMatch(csumMatch), .strb(strb),
    .busy(busy), .doneP(doneP), .frameErrP(frameErrP), .csumErrP(csumErrP),
    .zeroStopP(zeroStopP)
  );

  lin_rsp_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pid(pid), .enhanced(enhanced),
    .dataOut(dataOut), .shByte(shByte), .csumMatch(csumMatch)
  );
endmodule

// File: tb/test_lin_rsp_rx.sv
module test_lin_rsp_rx;
  localparam int OVS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  dataLen = 3'd0;
  logic [7:0]  pid = 8'd0;
  logic        enhanced = 1'b0;
  logic        afterHdr = 1'b0;
  logic [63:0] dataOut;
  logic        busy, doneP, frameErrP, csumErrP, zeroStopP;

  int checks = 0, fails = 0;
  int nDone = 0, nFe = 0, nCe = 0, nZero = 0;
  logic [7:0] dat [8];
  bit finished = 0;

  always #2 clk = ~clk;

  lin_rsp_rx #(.OVS(OVS)) i_lin_rsp_rx (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .start(start), .dataLen(dataLen),
    .pid(pid), .enhanced(enhanced), .afterHdr(afterHdr), .dataOut(dataOut),
    .busy(busy), .doneP(doneP), .frameErrP(frameErrP), .csumErrP(csumErrP),
    .zeroStopP(zeroStopP)
  );

  // pulse counters, sampled away from the active edge
  always @(negedge clk) if (rstN) begin
    nDone += int'(doneP);
    nFe   += int'(frameErrP);
    nCe   += int'(csumErrP);
    nZero += int'(zeroStopP);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] refCsum(input logic [7:0] init, input int n);
    int s = int'(init);
    for (int i = 0; i < n; i++) begin
      s += int'(dat[i]);
      if (s > 255) s -= 255;
    end
    return ~(8'(s));
  endfunction

  task automatic sendByte(input logic [7:0] b, input logic stopOk);
    rxIn = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (OVS) @(negedge clk);
    end
    rxIn = stopOk;
    repeat (OVS) @(negedge clk);
    rxIn = 1'b1;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic armRx(input int n, input logic enh, input logic [7:0] p, input logic hdr);
    dataLen = 3'(n - 1); enhanced = enh; pid = p; afterHdr = hdr;
    nDone = 0; nFe = 0; nCe = 0; nZero = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // n data bytes from dat[], then checksum (computed in the chosen mode, xored with csumXor)
  task automatic runFrame(input int n, input logic enh, input logic [7:0] p, input logic hdr,
                          input logic csEnh, input int badStop, input logic [7:0] csumXor,
                          input logic midStart);
    logic [7:0] cs;
    armRx(n, enh, p, hdr);
    cs = refCsum(csEnh ? p : 8'd0, n) ^ csumXor;
    for (int i = 0; i <= n; i++) begin
      sendByte((i == n) ? cs : dat[i], i != badStop);
      if (midStart && i == 2) begin
        dataLen = 3'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dataLen = 3'(n - 1);
      end
    end
    repeat (2 * OVS) @(negedge clk);
  endtask

  task automatic expectEnd(input string tag, input int d, input int fe, input int ce, input int z);
    chk({tag, " done"}, 64'(nDone), 64'(d));
    chk({tag, " frameErr"}, 64'(nFe), 64'(fe));
    chk({tag, " csumErr"}, 64'(nCe), 64'(ce));
    chk({tag, " zeroStop"}, 64'(nZero), 64'(z));
    chk({tag, " busy"}, 64'(busy), 64'd0);
  endtask

  task automatic expectData(input string tag, input int n);
    for (int k = 0; k < 8; k++)
      chk($sformatf("%s byte%0d", tag, k), 64'(dataOut[8*k +: 8]), (k < n) ? 64'(dat[k]) : 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 dataOut", dataOut, 64'd0);
    chk("R1 pulses", 64'({doneP, frameErrP, csumErrP, zeroStopP}), 64'd0);

    // R5 R3 R2: enhanced, 8 bytes with carries, start pulse mid-frame ignored
    dat = '{8'hFF, 8'h80, 8'h7F, 8'h01, 8'hAA, 8'h55, 8'hFE, 8'h10};
    runFrame(8, 1'b1, 8'hC1, 1'b1, 1'b1, -1, 8'h00, 1'b1);
    expectEnd("R5 R2 enhanced8", 1, 0, 0, 0);
    expectData("R3 enhanced8", 8);

    // R4 R3: classic, 2 bytes, upper bytes cleared by start
    dat = '{8'h4A, 8'hF3, 0, 0, 0, 0, 0, 0};
    runFrame(2, 1'b0, 8'h92, 1'b0, 1'b0, -1, 8'h00, 1'b0);
    expectEnd("R4 classic2", 1, 0, 0, 0);
    expectData("R3 classic2", 2);

    // R5 R6: enhanced mode given the classic checksum
    dat = '{8'h12, 8'h34, 8'h56, 0, 0, 0, 0, 0};
    runFrame(3, 1'b1, 8'h3C, 1'b0, 1'b0, -1, 8'h00, 1'b0);
    expectEnd("R5 R6 pidIncluded", 0, 0, 1, 0);

    // R4 R6: minimal length one zero byte
    dat = '{8'h00, 0, 0, 0, 0, 0, 0, 0};
    runFrame(1, 1'b0, 8'h55, 1'b0, 1'b0, -1, 8'h00, 1'b0);
    expectEnd("R4 R6 len1", 1, 0, 0, 0);

    // R6: corrupted checksum
    dat = '{8'h11, 8'hE0, 8'h9D, 0, 0, 0, 0, 0};
    runFrame(3, 1'b0, 8'h20, 1'b0, 1'b0, -1, 8'h01, 1'b0);
    expectEnd("R6 badCsum", 0, 0, 1, 0);

    // R7: bad stop on second data byte, later bytes ignored
    dat = '{8'h31, 8'h42, 8'h53, 8'h64, 0, 0, 0, 0};
    runFrame(4, 1'b0, 8'h20, 1'b1, 1'b0, 1, 8'h00, 1'b0);
    expectEnd("R7 badStop", 0, 1, 0, 0);

    // R8: zero first byte with bad stop after header
    dat = '{8'h00, 8'h42, 0, 0, 0, 0, 0, 0};
    runFrame(2, 1'b0, 8'h20, 1'b1, 1'b0, 0, 8'h00, 1'b0);
    expectEnd("R8 zeroAfterHdr", 0, 0, 0, 1);

    // R8 R7: same without header flag gives frame error
    runFrame(2, 1'b0, 8'h20, 1'b0, 1'b0, 0, 8'h00, 1'b0);
    expectEnd("R8 zeroNoHdr", 0, 1, 0, 0);

    // R8 R7: nonzero first byte with bad stop after header
    dat = '{8'h21, 8'h42, 0, 0, 0, 0, 0, 0};
    runFrame(2, 1'b0, 8'h20, 1'b1, 1'b0, 0, 8'h00, 1'b0);
    expectEnd("R8 nonzeroHdr", 0, 1, 0, 0);

    // R7: start glitch shorter than half a bit
    armRx(2, 1'b0, 8'h00, 1'b0);
    rxIn = 1'b0;
    repeat (3) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    expectEnd("R7 badStart", 0, 1, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule